// File: doc/BRIEF.md
# Converter Start Trigger Selector with Delay

This block issues the start-of-conversion pulse for one analog-to-digital converter. A 4-bit source code selects one of twelve hardware event inputs: an external start pin, six PWM channels, three timers, or the end-of-conversion flag of either converter. For a PWM source, a 2-bit field selects which PWM event counts. For the external pin, a 2-bit field selects which edge counts. Hardware events count only while a hardware-trigger enable is set. A software start request is merged in independently of that enable.

An accepted trigger sets an armed flag that the block clears by itself. After a programmable delay of four system clocks per unit of an 8-bit delay value, the block drives a single-cycle start pulse. Triggers are ignored in three cases: while a delay is counting, in the cycle the start pulse is out, and while the converter reports busy. A chip uses two instances, one per converter, and cross-wires their end-of-conversion flags to both.

All event inputs are synchronous single-cycle pulses, except the start pin. The start pin is asynchronous and is resynchronised inside the block. There is no data stream, so every pin is a plain control or status signal with no handshake.

Top module: `adcx_trig_unit`

## Requirements
- R1: With `hw_en`=1, source code 0 selects the start pin, codes 1..6 select PWM channels 0..5, codes 7..9 select timers 0..2, code 10 selects `eoc0` and code 11 selects `eoc1`. An event on any input that is not selected produces no start.
- R2: For a PWM source, `pwm_sel` picks the event that counts: 00 falling edge, 01 counter centre, 10 rising edge, 11 period. The other three PWM events of that channel produce no start.
- R3: For source 0, `pin_sel` picks the pin edge that counts: 00 rising, 01 falling, 10 either, 11 none. The pin passes two synchroniser flops. When the pin changes before clock edge a and the delay is 0, `conv_start` is high after edge a+2.
- R4: Hardware events produce no start while `hw_en`=0. A `sw_start` pulse starts a conversion regardless of `hw_en`.
- R5: Source codes 12..15 never produce a start from any hardware event.
- R6: When a trigger is accepted at clock edge k, `conv_start` is high during the cycle after edge k+4*`dly`. With `dly`=0 this is the cycle right after edge k.
- R7: `conv_start` lasts exactly one cycle. With `dly`>0, `start_armed` is 1 from the accepting edge until the edge that raises `conv_start`, and it is 0 otherwise.
- R8: A trigger is ignored while `start_armed`=1, while `conv_start`=1, or while `conv_busy`=1. It neither restarts the delay nor causes a second start.
- R9: After reset, `conv_start` and `start_armed` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_en | input | 1 | Hardware-trigger enable |
| src_sel | input | 4 | Trigger source code |
| pwm_sel | input | 2 | PWM event select |
| pin_sel | input | 2 | Start pin edge select |
| dly | input | 8 | Start delay in units of four clocks |
| sw_start | input | 1 | Software start request pulse |
| start_pin | input | 1 | Asynchronous external start pin |
| pwm_fall | input | 6 | PWM falling-edge events, one per channel |
| pwm_mid | input | 6 | PWM counter-centre events |
| pwm_rise | input | 6 | PWM rising-edge events |
| pwm_period | input | 6 | PWM period events |
| tmr_evt | input | 3 | Timer events |
| eoc0 | input | 1 | End-of-conversion flag pulse, converter 0 |
| eoc1 | input | 1 | End-of-conversion flag pulse, converter 1 |
| conv_busy | input | 1 | Converter busy |
| conv_start | output | 1 | Start-of-conversion pulse |
| start_armed | output | 1 | Trigger accepted, delay counting |

## Verification
Faults show up in two ways at the ports. A wrong source or qualifier decode shows as a start pulse missing or appearing in the cycle after the event edge, or three edges after a pin change. A corrupted delay counter or armed flag shows as a start pulse displaced from edge k+4*`dly`, as a second pulse, or as `start_armed` staying high. Any of these becomes visible within at most 4*`dly`+1 cycles of the trigger. The bench measures the start latency to the exact cycle for each source, event kind, pin edge and delay. It also watches for stray starts over a twelve-cycle window after every stimulus that must be ignored.

// File: rtl/adct_pkg.sv
package adct_pkg;
  typedef enum logic [1:0] {
    PWM_FALL = 2'b00,
    PWM_MID  = 2'b01,
    PWM_RISE = 2'b10,
    PWM_PER  = 2'b11
  } pwm_evt_e;

  typedef enum logic [1:0] {
    PIN_RISE = 2'b00,
    PIN_FALL = 2'b01,
    PIN_BOTH = 2'b10,
    PIN_NONE = 2'b11
  } pin_edge_e;

  localparam int SRC_W = 4;
endpackage

// File: rtl/pin_edge_det.sv
module pin_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] edge_sel,
  output logic       hit
);
  import adct_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   lvl;
  logic                   rise;
  logic                   fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign lvl  = sync_q[SYNC_STAGES-1];
  assign rise = lvl & ~last_q;
  assign fall = ~lvl & last_q;

  always_comb begin
    case (edge_sel)
      PIN_RISE: hit = rise;
      PIN_FALL: hit = fall;
      PIN_BOTH: hit = rise | fall;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/trig_src_mux.sv
module trig_src_mux #(
  parameter int NUM_PWM = 6,
  parameter int NUM_TMR = 3,
  parameter int SRC_W   = 4
) (
  input  logic               pin_hit,
  input  logic [NUM_PWM-1:0] pwm_fall,
  input  logic [NUM_PWM-1:0] pwm_mid,
  input  logic [NUM_PWM-1:0] pwm_rise,
  input  logic [NUM_PWM-1:0] pwm_period,
  input  logic [NUM_TMR-1:0] tmr_evt,
  input  logic               eoc0,
  input  logic               eoc1,
  input  logic [SRC_W-1:0]   src_sel,
  input  logic [1:0]         pwm_sel,
  output logic               hw_hit
);
  import adct_pkg::*;

  localparam int NSRC     = 1 << SRC_W;
  localparam int PWM_BASE = 1;
  localparam int TMR_BASE = PWM_BASE + NUM_PWM;
  localparam int EOC_BASE = TMR_BASE + NUM_TMR;
  localparam int USED     = EOC_BASE + 2;

  logic [NSRC-1:0] vec;

  assign vec[0] = pin_hit;

  for (genvar g = 0; g < NUM_PWM; g++) begin : g_pwm
    assign vec[PWM_BASE+g] = (pwm_sel == PWM_FALL) ? pwm_fall[g] :
                             (pwm_sel == PWM_MID)  ? pwm_mid[g]  :
                             (pwm_sel == PWM_RISE) ? pwm_rise[g] :
                                                     pwm_period[g];
  end

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    assign vec[TMR_BASE+g] = tmr_evt[g];
  end

  assign vec[EOC_BASE]   = eoc0;
  assign vec[EOC_BASE+1] = eoc1;

  for (genvar g = USED; g < NSRC; g++) begin : g_dead
    assign vec[g] = 1'b0;
  end

  assign hw_hit = vec[src_sel];
endmodule

// File: rtl/start_delay.sv
module start_delay #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             conv_busy,
  input  logic [DLY_W-1:0] dly,
  output logic             conv_start,
  output logic             armed
);
  localparam int CNT_W = DLY_W + 2;

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             start_q;
  logic             accept;

  assign accept = trig & ~armed_q & ~start_q & ~conv_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (armed_q) begin
        if (cnt_q == CNT_W'(1)) begin
          start_q <= 1'b1;
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end else if (accept) begin
        if (dly == '0) begin
          start_q <= 1'b1;
        end else begin
          armed_q <= 1'b1;
          cnt_q   <= {dly, 2'b00};
        end
      end
    end
  end

  assign conv_start = start_q;
  assign armed      = armed_q;
endmodule

// File: rtl/adcx_trig_unit.sv
module adcx_trig_unit #(
  parameter int NUM_PWM     = 6,
  parameter int NUM_TMR     = 3,
  parameter int DLY_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hw_en,
  input  logic [3:0]         src_sel,
  input  logic [1:0]         pwm_sel,
  input  logic [1:0]         pin_sel,
  input  logic [DLY_W-1:0]   dly,
  input  logic               sw_start,
  input  logic               start_pin,
  input  logic [NUM_PWM-1:0] pwm_fall,
  input  logic [NUM_PWM-1:0] pwm_mid,
  input  logic [NUM_PWM-1:0] pwm_rise,
  input  logic [NUM_PWM-1:0] pwm_period,
  input  logic [NUM_TMR-1:0] tmr_evt,
  input  logic               eoc0,
  input  logic               eoc1,
  input  logic               conv_busy,
  output logic               conv_start,
  output logic               start_armed
);
  logic pin_hit;
  logic hw_hit;
  logic trig;

  pin_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (start_pin),
    .edge_sel (pin_sel),
    .hit      (pin_hit)
  );

  trig_src_mux #(.NUM_PWM(NUM_PWM), .NUM_TMR(NUM_TMR), .SRC_W(4)) u_mux (
    .pin_hit    (pin_hit),
    .pwm_fall   (pwm_fall),
    .pwm_mid    (pwm_mid),
    .pwm_rise   (pwm_rise),
    .pwm_period (pwm_period),
    .tmr_evt    (tmr_evt),
    .eoc0       (eoc0),
    .eoc1       (eoc1),
    .src_sel    (src_sel),
    .pwm_sel    (pwm_sel),
    .hw_hit     (hw_hit)
  );

  assign trig = (hw_en & hw_hit) | sw_start;

  start_delay #(.DLY_W(DLY_W)) u_dly (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig),
    .conv_busy  (conv_busy),
    .dly        (dly),
    .conv_start (conv_start),
    .armed      (start_armed)
  );
endmodule

// File: rtl/adcx_trig_chk.sv
module adcx_trig_chk #(
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hw_en,
  input logic [3:0]       src_sel,
  input logic [DLY_W-1:0] dly,
  input logic             sw_start,
  input logic             conv_busy,
  input logic             conv_start,
  input logic             start_armed
);
  // R7
  one_cycle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R7
  armed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_armed) |-> conv_start);

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy && !start_armed) |=> (!start_armed && !conv_start));

  // R4
  hw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_en && !sw_start && !start_armed) |=> !conv_start);

  // R5
  dead_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel >= 4'd12 && !sw_start && !start_armed) |=> !conv_start);

  // R6
  zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_start && dly == '0 && !start_armed && !conv_start && !conv_busy) |=> conv_start);
endmodule

bind adcx_trig_unit adcx_trig_chk #(.DLY_W(DLY_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hw_en       (hw_en),
  .src_sel     (src_sel),
  .dly         (dly),
  .sw_start    (sw_start),
  .conv_busy   (conv_busy),
  .conv_start  (conv_start),
  .start_armed (start_armed)
);

// File: tb/sim_adcx_trig_unit.sv
module sim_adcx_trig_unit;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_en = 1'b0;
  logic [3:0] src_sel = '0;
  logic [1:0] pwm_sel = '0;
  logic [1:0] pin_sel = '0;
  logic [7:0] dly = '0;
  logic       sw_start = 1'b0;
  logic       start_pin = 1'b0;
  logic [5:0] pwm_fall = '0;
  logic [5:0] pwm_mid = '0;
  logic [5:0] pwm_rise = '0;
  logic [5:0] pwm_period = '0;
  logic [2:0] tmr_evt = '0;
  logic       eoc0 = 1'b0;
  logic       eoc1 = 1'b0;
  logic       conv_busy = 1'b0;
  logic       conv_start;
  logic       start_armed;

  int errs = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  adcx_trig_unit u0 (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .src_sel(src_sel),
    .pwm_sel(pwm_sel), .pin_sel(pin_sel), .dly(dly), .sw_start(sw_start),
    .start_pin(start_pin), .pwm_fall(pwm_fall), .pwm_mid(pwm_mid),
    .pwm_rise(pwm_rise), .pwm_period(pwm_period), .tmr_evt(tmr_evt),
    .eoc0(eoc0), .eoc1(eoc1), .conv_busy(conv_busy),
    .conv_start(conv_start), .start_armed(start_armed)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // code 99 = software start, code 50 = every hardware event at once
  task automatic set_evt(input int code, input int kind, input bit v);
    if (code == 99) sw_start = v;
    else if (code == 50) begin
      pwm_fall = {6{v}}; pwm_mid = {6{v}}; pwm_rise = {6{v}};
      pwm_period = {6{v}}; tmr_evt = {3{v}}; eoc0 = v; eoc1 = v;
    end else if (code >= 1 && code <= 6) begin
      case (kind)
        0: pwm_fall[code-1] = v;
        1: pwm_mid[code-1] = v;
        2: pwm_rise[code-1] = v;
        default: pwm_period[code-1] = v;
      endcase
    end else if (code >= 7 && code <= 9) tmr_evt[code-7] = v;
    else if (code == 10) eoc0 = v;
    else if (code == 11) eoc1 = v;
  endtask

  // exp_lat < 0: no start allowed within 12 cycles
  task automatic wait_start(input int exp_lat, input string req);
    int lat = 0;
    int lim = (exp_lat < 0) ? 12 : exp_lat + 4;
    int got;
    while (!conv_start && lat < lim) begin
      @(negedge clk);
      lat++;
    end
    got = conv_start ? lat : -1;
    chk(got == exp_lat, req, got, exp_lat);
    repeat (3) @(negedge clk);
  endtask

  task automatic fire(input int code, input int kind, input int exp_lat, input string req);
    set_evt(code, kind, 1'b1);
    @(negedge clk);
    set_evt(code, kind, 1'b0);
    wait_start(exp_lat, req);
  endtask

  task automatic t_reset;
    chk(conv_start == 1'b0, "R9 start", int'(conv_start), 0);
    chk(start_armed == 1'b0, "R9 armed", int'(start_armed), 0);
  endtask

  task automatic t_sw;
    hw_en = 1'b0; dly = 8'd0;
    fire(99, 0, 0, "R4 sw start with hw_en=0");
    fire(99, 0, 0, "R6 zero delay");
  endtask

  task automatic t_delay;
    hw_en = 1'b0;
    dly = 8'd3;
    set_evt(99, 0, 1'b1); @(negedge clk); set_evt(99, 0, 1'b0);
    chk(start_armed == 1'b1, "R7 armed while counting", int'(start_armed), 1);
    wait_start(12, "R6 dly=3");
    chk(start_armed == 1'b0, "R7 armed self-clears", int'(start_armed), 0);
    dly = 8'd255;
    fire(99, 0, 1020, "R6 dly=255");
    dly = 8'd1;
    fire(99, 0, 4, "R6 dly=1");
    dly = 8'd0;
  endtask

  task automatic t_sources;
    hw_en = 1'b1; dly = 8'd0; pwm_sel = 2'b10;
    for (int c = 1; c <= 11; c++) begin
      src_sel = 4'(c);
      fire(c, 2, 0, $sformatf("R1 source %0d", c));
    end
    src_sel = 4'd7;
    fire(10, 0, -1, "R1 unselected eoc0");
    src_sel = 4'd11;
    fire(3, 2, -1, "R1 unselected pwm");
  endtask

  task automatic t_pwm;
    hw_en = 1'b1; dly = 8'd0; src_sel = 4'd3;
    for (int k = 0; k < 4; k++) begin
      pwm_sel = 2'(k);
      fire(3, k, 0, $sformatf("R2 kind %0d counts", k));
      fire(3, (k + 1) % 4, -1, $sformatf("R2 kind %0d ignored", (k + 1) % 4));
    end
  endtask

  task automatic t_gate;
    hw_en = 1'b0; src_sel = 4'd1; pwm_sel = 2'b10;
    fire(1, 2, -1, "R4 hw_en=0 blocks pwm");
    src_sel = 4'd8;
    fire(8, 0, -1, "R4 hw_en=0 blocks timer");
    hw_en = 1'b1;
  endtask

  task automatic t_dead;
    hw_en = 1'b1;
    for (int c = 12; c <= 15; c++) begin
      src_sel = 4'(c);
      fire(50, 0, -1, $sformatf("R5 code %0d", c));
    end
  endtask

  task automatic pin_to(input bit v, input int exp_lat, input string req);
    start_pin = v;
    wait_start(exp_lat, req);
  endtask

  task automatic t_pin;
    hw_en = 1'b1; src_sel = 4'd0; dly = 8'd0;
    pin_sel = 2'b00;
    pin_to(1'b1, 3, "R3 rise sel, rising");
    pin_to(1'b0, -1, "R3 rise sel, falling");
    pin_sel = 2'b01;
    pin_to(1'b1, -1, "R3 fall sel, rising");
    pin_to(1'b0, 3, "R3 fall sel, falling");
    pin_sel = 2'b10;
    pin_to(1'b1, 3, "R3 both sel, rising");
    pin_to(1'b0, 3, "R3 both sel, falling");
    pin_sel = 2'b11;
    pin_to(1'b1, -1, "R3 code 11, rising");
    pin_to(1'b0, -1, "R3 code 11, falling");
  endtask

  task automatic t_block;
    hw_en = 1'b1; src_sel = 4'd1; pwm_sel = 2'b10; dly = 8'd0;
    conv_busy = 1'b1;
    fire(1, 2, -1, "R8 busy ignores trigger");
    fire(99, 0, -1, "R8 busy ignores sw");
    conv_busy = 1'b0;
    // second trigger during delay count
    dly = 8'd2;
    set_evt(99, 0, 1'b1); @(negedge clk); set_evt(99, 0, 1'b0);
    @(negedge clk);
    set_evt(1, 2, 1'b1); @(negedge clk); set_evt(1, 2, 1'b0);
    wait_start(6, "R8 no restart while armed");
    wait_start(-1, "R8 no second start");
    // trigger during start cycle
    dly = 8'd0;
    set_evt(99, 0, 1'b1); @(negedge clk);
    chk(conv_start == 1'b1, "R8 first start", int'(conv_start), 1);
    @(negedge clk); set_evt(99, 0, 1'b0);
    chk(conv_start == 1'b0, "R8 ignored during start", int'(conv_start), 0);
    wait_start(-1, "R8 nothing later");
  endtask

  initial begin
    #(CLK_P * 150000);
    errs++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sw();
    t_delay();
    t_sources();
    t_pwm();
    t_gate();
    t_dead();
    t_pin();
    t_block();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule